// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer whose width is set by a parameter (typically 32 or 64 bits). The operand arrives already split into a class code, a sign, a signed unbiased exponent, a mantissa whose two lowest bits act as guard and round bits, and a separate sticky bit. The conversion always chops toward zero. It has no rounding-mode input, so the direction of rounding is fixed.

Along with the integer, the block reports two exception flags. The inexact flag is raised when any fraction bit is thrown away. The invalid flag is raised when the value cannot be represented. Values that are out of range, infinite or not-a-number saturate to a pattern chosen by the sign. Whenever invalid is raised, inexact is suppressed. The path is a two-stage register pipeline with a valid strobe. It accepts one operand per clock and produces each result two clocks after its operand.

Top module: `fti_conv`

## Requirements
- R1: A result appears on the outputs exactly two clock edges after its operand is presented with `in_valid` high, and `out_valid` marks it. A synchronous reset clears both stages, leaving `out_valid` low and `out_int` at zero.
- R2: An operand of class zero (class code 0) yields 0 with both flags low, whatever its sign, exponent, mantissa or sticky bit.
- R3: For a number (class code 1), the magnitude is the integer part of |x|, with x = mant × 2^(exp − (MANT_W−1)); mantissa bit MANT_W−1 therefore carries weight 2^exp. The result is always chopped toward zero.
- R4: Inexact is raised when any discarded bit is nonzero. This includes the two lowest mantissa bits (guard and round) and the sticky bit.
- R5: A number with a negative exponent yields 0. Inexact is raised in that case only if some mantissa bit or the sticky bit is set.
- R6: A number whose exponent is greater than or equal to INT_W is reported as invalid.
- R7: A positive magnitude of 2^(INT_W−1) or more is invalid. A negative magnitude is invalid only above 2^(INT_W−1), so −2^(INT_W−1) is returned without any flag.
- R8: An in-range negative number is returned as the two's-complement negation of its truncated magnitude.
- R9: Infinity (code 2), quiet NaN (code 3) and signaling NaN (code 4) are all invalid.
- R10: An invalid result is 0111…1 for sign 0 and 1000…0 for sign 1. Inexact is low on every invalid result, even when fraction bits were discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_cls | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signaling NaN |
| in_sign | input | 1 | Operand sign, 1 means negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa; the top bit has weight 2^exp and the lowest two bits are guard and round |
| in_sticky | input | 1 | OR of all bits below the mantissa |
| out_valid | output | 1 | Result strobe |
| out_int | output | INT_W | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Value not representable; result saturated |

## Verification
The bench builds the block with INT_W=32, MANT_W=40 and EXP_W=10. Because the mantissa is wider than the integer, every in-range exponent leaves at least eight mantissa bits below the cut. This lets the bench check, one bit at a time, that a lone guard bit, a lone round bit or the sticky bit alone raises inexact. The 10-bit exponent covers small negative exponents and values far past the integer range, such as 400. The 32-bit width makes the asymmetric edge at ±2^31 reachable, including the case where the negative edge has fraction bits and the case just past it.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [2:0] {
    FCLS_ZERO = 3'd0,
    FCLS_NUM  = 3'd1,
    FCLS_INF  = 3'd2,
    FCLS_QNAN = 3'd3,
    FCLS_SNAN = 3'd4
  } fcls_e;

endpackage

// File: rtl/fti_align.sv
// Moves the integer part of the mantissa into an INT_W-bit field and
// reports whether any bit fell off below the binary point.
module fti_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 56,
  parameter int EXP_W  = 12
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  input  logic                     sticky_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     lost_o,
  output logic                     big_o
);
  localparam int WIDE_W = INT_W + MANT_W;
  localparam int SH_W   = $clog2(INT_W + 1);
  localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

  if (EXP_W < $clog2(INT_W) + 2) begin : g_bad_exp
    $error("fti_align: EXP_W too narrow for INT_W");
  end

  logic              neg_exp;
  logic [SH_W-1:0]   shamt;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    neg_exp = exp_i[EXP_W-1];
    big_o   = !neg_exp && (exp_i >= EXP_LIM);
    shamt   = '0;
    if (!neg_exp && !big_o) begin
      shamt = SH_W'(exp_i) + SH_W'(1);
    end
    wide = {{INT_W{1'b0}}, mant_i} << shamt;
    if (neg_exp || big_o) begin
      mag_o  = '0;
      lost_o = (|mant_i) | sticky_i;
    end else begin
      mag_o  = wide[WIDE_W-1 -: INT_W];
      lost_o = (|wide[MANT_W-1:0]) | sticky_i;
    end
  end
endmodule

// File: rtl/fti_range.sv
// Decides whether the aligned magnitude fits a signed INT_W-bit result.
module fti_range
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fcls_e             cls_i,
  input  logic              sign_i,
  input  logic [INT_W-1:0]  mag_i,
  input  logic              big_i,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam logic [INT_W:0] HALF = {2'b01, {(INT_W-1){1'b0}}};

  logic [INT_W:0] limit;
  logic           num_ovf;

  always_comb begin
    limit   = HALF + (INT_W+1)'(sign_i);
    num_ovf = big_i || ({1'b0, mag_i} >= limit);
    zero_o  = (cls_i == FCLS_ZERO);
    unique case (cls_i)
      FCLS_ZERO: ovf_o = 1'b0;
      FCLS_NUM:  ovf_o = num_ovf;
      default:   ovf_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fti_pack.sv
// Forms the final integer and flags from the range decision.
module fti_pack #(
  parameter int INT_W = 32
) (
  input  logic              zero_i,
  input  logic              ovf_i,
  input  logic              sign_i,
  input  logic [INT_W-1:0]  mag_i,
  input  logic              lost_i,
  output logic [INT_W-1:0]  res_o,
  output logic              inexact_o,
  output logic              invalid_o
);
  logic [INT_W-1:0] sat;

  always_comb begin
    sat = {sign_i, {(INT_W-1){~sign_i}}};
    if (zero_i) begin
      res_o     = '0;
      inexact_o = 1'b0;
      invalid_o = 1'b0;
    end else if (ovf_i) begin
      res_o     = sat;
      inexact_o = 1'b0;
      invalid_o = 1'b1;
    end else begin
      res_o     = sign_i ? ('0 - mag_i) : mag_i;
      inexact_o = lost_i;
      invalid_o = 1'b0;
    end
  end
endmodule

// File: rtl/fti_conv.sv
module fti_conv
  import fti_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 56,
  parameter int EXP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [2:0]               in_cls,
  input  logic                     in_sign,
  input  logic signed [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0]        in_mant,
  input  logic                     in_sticky,
  output logic                     out_valid,
  output logic [INT_W-1:0]         out_int,
  output logic                     out_inexact,
  output logic                     out_invalid
);
  // stage A: aligned operand
  logic [INT_W-1:0] al_mag;
  logic             al_lost, al_big;
  logic             a_vld, a_sign, a_lost, a_big;
  fcls_e            a_cls;
  logic [INT_W-1:0] a_mag;

  // stage B: decision and packing
  logic             b_zero, b_ovf, b_inx, b_inv;
  logic [INT_W-1:0] b_res;

  fti_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i    (in_exp),
    .mant_i   (in_mant),
    .sticky_i (in_sticky),
    .mag_o    (al_mag),
    .lost_o   (al_lost),
    .big_o    (al_big)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld  <= 1'b0;
      a_cls  <= FCLS_ZERO;
      a_sign <= 1'b0;
      a_mag  <= '0;
      a_lost <= 1'b0;
      a_big  <= 1'b0;
    end else begin
      a_vld <= in_valid;
      if (in_valid) begin
        a_cls  <= fcls_e'(in_cls);
        a_sign <= in_sign;
        a_mag  <= al_mag;
        a_lost <= al_lost;
        a_big  <= al_big;
      end
    end
  end

  fti_range #(.INT_W(INT_W)) u_range (
    .cls_i  (a_cls),
    .sign_i (a_sign),
    .mag_i  (a_mag),
    .big_i  (a_big),
    .zero_o (b_zero),
    .ovf_o  (b_ovf)
  );

  fti_pack #(.INT_W(INT_W)) u_pack (
    .zero_i    (b_zero),
    .ovf_i     (b_ovf),
    .sign_i    (a_sign),
    .mag_i     (a_mag),
    .lost_i    (a_lost),
    .res_o     (b_res),
    .inexact_o (b_inx),
    .invalid_o (b_inv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= a_vld;
      if (a_vld) begin
        out_int     <= b_res;
        out_inexact <= b_inx;
        out_invalid <= b_inv;
      end
    end
  end
endmodule

// File: rtl/fti_conv_chk.sv
module fti_conv_chk
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       in_cls,
  input logic             in_sign,
  input logic             out_valid,
  input logic [INT_W-1:0] out_int,
  input logic             out_inexact,
  input logic             out_invalid
);
  localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid); // R1

  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == FCLS_ZERO) |-> ##2
      (out_int == '0 && !out_inexact && !out_invalid)); // R2

  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_cls == FCLS_INF || in_cls == FCLS_QNAN || in_cls == FCLS_SNAN))
      |-> ##2 out_invalid); // R9

  AST_SAT_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |->
      (out_int == ($past(in_sign, 2) ? SAT_NEG : SAT_POS))); // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_invalid && out_inexact)); // R10

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_invalid && out_int != '0) |->
      (out_int[INT_W-1] == $past(in_sign, 2))); // R8
endmodule

bind fti_conv fti_conv_chk #(.INT_W(INT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_cls      (in_cls),
  .in_sign     (in_sign),
  .out_valid   (out_valid),
  .out_int     (out_int),
  .out_inexact (out_inexact),
  .out_invalid (out_invalid)
);

// File: tb/fti_conv_tb.sv
module fti_conv_tb;
  import fti_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 32;
  localparam int MANT_W = 40;
  localparam int EXP_W  = 10;

  typedef struct packed {
    logic [2:0]        cls;
    logic              sg;
    logic [EXP_W-1:0]  ex;
    logic [MANT_W-1:0] mt;
    logic              st;
    logic [INT_W-1:0]  res;
    logic              inx;
    logic              inv;
    logic [3:0]        rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 10'd5,   40'hFFFFFFFFFF, 1'b1, 32'h00000000, 1'b0, 1'b0, 4'd2},  // R2 garbage zero
    '{3'd0, 1'b0, 10'h3FD, 40'h0000000000, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd2},  // R2
    '{3'd1, 1'b0, 10'd0,   40'h8000000000, 1'b0, 32'h00000001, 1'b0, 1'b0, 4'd3},  // R3 1.0
    '{3'd1, 1'b0, 10'd0,   40'hC000000000, 1'b0, 32'h00000001, 1'b1, 1'b0, 4'd3},  // R3 1.5
    '{3'd1, 1'b1, 10'd0,   40'hC000000000, 1'b0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd8},  // R8 -1.5
    '{3'd1, 1'b0, 10'd1,   40'hB000000000, 1'b0, 32'h00000002, 1'b1, 1'b0, 4'd3},  // R3 2.75
    '{3'd1, 1'b1, 10'd1,   40'hB000000000, 1'b0, 32'hFFFFFFFE, 1'b1, 1'b0, 4'd8},  // R8 -2.75
    '{3'd1, 1'b0, 10'd0,   40'h8000000001, 1'b0, 32'h00000001, 1'b1, 1'b0, 4'd4},  // R4 round bit
    '{3'd1, 1'b0, 10'd0,   40'h8000000002, 1'b0, 32'h00000001, 1'b1, 1'b0, 4'd4},  // R4 guard bit
    '{3'd1, 1'b0, 10'd0,   40'h8000000000, 1'b1, 32'h00000001, 1'b1, 1'b0, 4'd4},  // R4 sticky
    '{3'd1, 1'b0, 10'h3FF, 40'h8000000000, 1'b0, 32'h00000000, 1'b1, 1'b0, 4'd5},  // R5 0.5
    '{3'd1, 1'b1, 10'h3FB, 40'h0000000000, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd5},  // R5 sticky only
    '{3'd1, 1'b0, 10'h3FE, 40'h0000000000, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5 exact
    '{3'd1, 1'b0, 10'd30,  40'hFFFFFFFE00, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b0, 4'd7},  // R7 max pos
    '{3'd1, 1'b0, 10'd31,  40'h8000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd7},  // R7 +2^31
    '{3'd1, 1'b1, 10'd31,  40'h8000000000, 1'b0, 32'h80000000, 1'b0, 1'b0, 4'd7},  // R7 -2^31
    '{3'd1, 1'b1, 10'd31,  40'h8000000100, 1'b0, 32'h80000000, 1'b0, 1'b1, 4'd10}, // R10 -(2^31+1)
    '{3'd1, 1'b1, 10'd31,  40'h8000000080, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd3},  // R3 -(2^31+0.5)
    '{3'd1, 1'b0, 10'd31,  40'h8000000080, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd10}, // R10 inexact dropped
    '{3'd1, 1'b0, 10'd32,  40'h8000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd1, 1'b1, 10'd400, 40'h8000000000, 1'b0, 32'h80000000, 1'b0, 1'b1, 4'd6},  // R6
    '{3'd2, 1'b0, 10'd0,   40'h0000000000, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd9},  // R9 inf
    '{3'd3, 1'b1, 10'd0,   40'hC000000000, 1'b0, 32'h80000000, 1'b0, 1'b1, 4'd9},  // R9 qnan
    '{3'd4, 1'b0, 10'd0,   40'hA000000000, 1'b1, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd9},  // R9 snan
    '{3'd1, 1'b1, 10'd28,  40'h91A2B3C000, 1'b0, 32'hEDCBA988, 1'b0, 1'b0, 4'd8},  // R8
    '{3'd1, 1'b0, 10'd28,  40'h91A2B3C000, 1'b0, 32'h12345678, 1'b0, 1'b0, 4'd3}   // R3
  };

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    in_valid;
  logic [2:0]              in_cls;
  logic                    in_sign;
  logic signed [EXP_W-1:0] in_exp;
  logic [MANT_W-1:0]       in_mant;
  logic                    in_sticky;
  logic                    out_valid;
  logic [INT_W-1:0]        out_int;
  logic                    out_inexact;
  logic                    out_invalid;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fti_conv #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .out_valid(out_valid), .out_int(out_int),
    .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  task automatic check(input string tag, input logic vld_e,
                       input logic [INT_W-1:0] res_e, input logic inx_e,
                       input logic inv_e);
    logic bad;
    n_chk++;
    bad = (out_valid !== vld_e);
    if (vld_e)
      bad = bad || (out_int !== res_e) || (out_inexact !== inx_e) ||
            (out_invalid !== inv_e);
    if (bad) begin
      n_err++;
      $display("FAIL %s: actual v=%b int=%h inx=%b inv=%b, expected v=%b int=%h inx=%b inv=%b",
               tag, out_valid, out_int, out_inexact, out_invalid,
               vld_e, res_e, inx_e, inv_e);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid  = 1'b1;
    in_cls    = v.cls;
    in_sign   = v.sg;
    in_exp    = v.ex;
    in_mant   = v.mt;
    in_sticky = v.st;
  endtask

  task automatic idle();
    in_valid  = 1'b0;
    in_cls    = 3'd0;
    in_sign   = 1'b0;
    in_exp    = '0;
    in_mant   = '0;
    in_sticky = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, '0, 1'b0, 1'b0);
    if (out_int !== '0) begin
      n_err++;
      $display("FAIL R1 reset int: actual %h expected 0", out_int);
    end
    n_chk++;
    rst = 1'b0;
    @(negedge clk);

    // table walk: drive, drop valid, sample two edges after drive
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      idle();
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].rq, i), 1'b1,
            VECS[i].res, VECS[i].inx, VECS[i].inv);
    end

    // R1: back-to-back operands, one result per clock, then idle
    drive(VECS[3]);
    @(negedge clk);
    drive(VECS[15]);
    @(negedge clk);
    idle();
    check("R1 stream first", 1'b1, 32'h00000001, 1'b1, 1'b0);
    @(negedge clk);
    check("R1 stream second", 1'b1, 32'h80000000, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 stream drains", 1'b0, '0, 1'b0, 1'b0);

    // R1: reset while an operand is in flight flushes it
    drive(VECS[24]);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle();
    check("R1 reset flush a", 1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 reset flush b", 1'b0, '0, 1'b0, 1'b0);

    report();
    $finish;
  end
endmodule